// File: doc/BRIEF.md
# Software-Generated Interrupt Acceptance Filter

This block sits in front of the pending bits of the 16 software-generated interrupt IDs of one processor. Each incoming request carries the target ID, the group asked for by the sender, and a flag that says whether the sender is non-secure. Alongside the request, the surrounding logic supplies the group configured for that ID and the global security-disable bit. The block decides whether the request may set the pending bit of the ID.

A request for Group 1 that targets an ID configured as Group 0 is treated as Group 0. After that conversion, any group mismatch drops the request. When security is enabled, a non-secure sender must also hold a high enough level in a per-ID 2-bit field of an access control register. This block owns that register, and only secure accesses made while security is enabled can read or write it.

The decision is registered. An accepted request produces a single-cycle pending-set pulse, together with its ID, one cycle after the request.

Top module: `sgi_accept_filter`

## Requirements
- R1: The access level of ID n sits in bits [2n+1:2n] of the 32-bit access control register, for n = 0 to 15.
- R2: A Group 1 request (req_grp1_i=1) to an ID configured as Group 0 (id_grp1_i=0) is handled as a Group 0 request.
- R3: After the R2 conversion, a request whose group differs from the configured group of the ID is dropped. This applies whatever the security settings are.
- R4: A non-secure request (req_ns_i=1) with security enabled (sec_dis_i=0) to a Group 0 ID is accepted only when the ID's access level is 1 or more.
- R5: A non-secure request with security enabled to a Group 1 ID is accepted only when the ID's access level is 2 or more.
- R6: With sec_dis_i=1, no access-level check is made.
- R7: A secure request (req_ns_i=0) is never subject to the access-level check.
- R8: An accepted request raises pend_set_o for exactly the one cycle after the request's valid cycle, with pend_id_o equal to the request ID. A dropped request, or a cycle without a request, leaves pend_set_o low.
- R9: acc_rdata_o reads zero when sec_dis_i=1 or acc_ns_i=1. Otherwise it shows the register contents.
- R10: A write (acc_wr_i=1) is ignored when sec_dis_i=1 or acc_ns_i=1.
- R11: The access control register resets to zero.
- R12: A request in the same cycle as a register write is judged against the register value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_dis_i | input | 1 | Global security disable |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_id_i | input | 4 | Target ID |
| req_grp1_i | input | 1 | Requested group: 1 = Group 1, 0 = Group 0 |
| req_ns_i | input | 1 | Sender is non-secure |
| id_grp1_i | input | 1 | Configured group of the target ID: 1 = Group 1 |
| acc_wr_i | input | 1 | Access register write strobe |
| acc_ns_i | input | 1 | Register access is non-secure |
| acc_wdata_i | input | 32 | Access register write data |
| acc_rdata_o | output | 32 | Access register read data |
| pend_set_o | output | 1 | Pending-set pulse |
| pend_id_o | output | 4 | ID for the pending-set pulse |

## Verification
The bench builds the block with its default of 16 IDs and 2-bit levels. This makes every level value 0 to 3 reachable, through a register pattern that repeats the four levels across the ID range. At these widths the top and bottom fields and the exact bit position of a single field are easy to probe. The vector table crosses each requested and configured group pairing with secure, non-secure and security-disabled senders. Directed cases cover the register access rules and a write that lands in the same cycle as a request.

// File: rtl/sgi_filt_pkg.sv
package sgi_filt_pkg;
  localparam int unsigned NUM_IDS_DEF = 16;
  localparam int unsigned LVL_W_DEF   = 2;
  // minimum access level for non-secure senders, per effective group
  localparam int unsigned MIN_LVL_G0  = 1;
  localparam int unsigned MIN_LVL_G1  = 2;

  typedef enum logic {
    GRP_0 = 1'b0,
    GRP_1 = 1'b1
  } grp_e;
endpackage

// File: rtl/sgi_acc_reg.sv
module sgi_acc_reg #(
  parameter int unsigned NUM_IDS = 16,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned REG_W  = NUM_IDS * LVL_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              sec_dis_i,
  input  logic                              wr_i,
  input  logic                              ns_i,
  input  logic [REG_W-1:0]                  wdata_i,
  output logic [REG_W-1:0]                  rdata_o,
  output logic [REG_W-1:0]                  q_o,
  output logic [NUM_IDS-1:0][LVL_W-1:0]     lvl_o
);
  logic [REG_W-1:0] q;
  logic             sec_ok;

  assign sec_ok = !sec_dis_i && !ns_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             q <= '0;
    else if (wr_i && sec_ok) q <= wdata_i;
  end

  assign rdata_o = sec_ok ? q : '0;
  assign q_o     = q;

  for (genvar n = 0; n < NUM_IDS; n++) begin : g_lvl
    assign lvl_o[n] = q[n*LVL_W +: LVL_W];
  end
endmodule

// File: rtl/sgi_accept_logic.sv
module sgi_accept_logic
  import sgi_filt_pkg::*;
#(
  parameter int unsigned LVL_W = 2
) (
  input  logic             sec_dis_i,
  input  logic             req_ns_i,
  input  grp_e             req_grp_i,
  input  grp_e             id_grp_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             accept_o
);
  localparam logic [LVL_W-1:0] MIN_G0 = LVL_W'(MIN_LVL_G0);
  localparam logic [LVL_W-1:0] MIN_G1 = LVL_W'(MIN_LVL_G1);

  grp_e eff_grp;
  logic grp_ok;
  logic lvl_ok;

  always_comb begin
    // Group 1 ask on a Group 0 ID is served as Group 0
    eff_grp = (req_grp_i == GRP_1 && id_grp_i == GRP_0) ? GRP_0 : req_grp_i;
    grp_ok  = (eff_grp == id_grp_i);
    if (req_ns_i && !sec_dis_i)
      lvl_ok = (id_grp_i == GRP_0) ? (lvl_i >= MIN_G0) : (lvl_i >= MIN_G1);
    else
      lvl_ok = 1'b1;
    accept_o = grp_ok && lvl_ok;
  end
endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
  import sgi_filt_pkg::*;
#(
  parameter int unsigned NUM_IDS = NUM_IDS_DEF,
  parameter int unsigned LVL_W   = LVL_W_DEF,
  localparam int unsigned REG_W  = NUM_IDS * LVL_W,
  localparam int unsigned ID_W   = $clog2(NUM_IDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_dis_i,
  input  logic             req_valid_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic             req_grp1_i,
  input  logic             req_ns_i,
  input  logic             id_grp1_i,
  input  logic             acc_wr_i,
  input  logic             acc_ns_i,
  input  logic [REG_W-1:0] acc_wdata_i,
  output logic [REG_W-1:0] acc_rdata_o,
  output logic             pend_set_o,
  output logic [ID_W-1:0]  pend_id_o
);
  logic [NUM_IDS-1:0][LVL_W-1:0] lvl;
  logic [REG_W-1:0]              nsacc_q;
  logic                          accept;

  sgi_acc_reg #(.NUM_IDS(NUM_IDS), .LVL_W(LVL_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_dis_i (sec_dis_i),
    .wr_i      (acc_wr_i),
    .ns_i      (acc_ns_i),
    .wdata_i   (acc_wdata_i),
    .rdata_o   (acc_rdata_o),
    .q_o       (nsacc_q),
    .lvl_o     (lvl)
  );

  sgi_accept_logic #(.LVL_W(LVL_W)) u_logic (
    .sec_dis_i (sec_dis_i),
    .req_ns_i  (req_ns_i),
    .req_grp_i (grp_e'(req_grp1_i)),
    .id_grp_i  (grp_e'(id_grp1_i)),
    .lvl_i     (lvl[req_id_i]),
    .accept_o  (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_set_o <= 1'b0;
      pend_id_o  <= '0;
    end else begin
      pend_set_o <= req_valid_i && accept;
      if (req_valid_i) pend_id_o <= req_id_i;
    end
  end
endmodule

// File: rtl/sgi_accept_filter_chk.sv
module sgi_accept_filter_chk #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned ID_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sec_dis_i,
  input logic             req_valid_i,
  input logic [ID_W-1:0]  req_id_i,
  input logic             req_grp1_i,
  input logic             req_ns_i,
  input logic             id_grp1_i,
  input logic             acc_wr_i,
  input logic             acc_ns_i,
  input logic [REG_W-1:0] acc_rdata_o,
  input logic [REG_W-1:0] nsacc_q,
  input logic             pend_set_o,
  input logic [ID_W-1:0]  pend_id_o
);
  p_pulse_needs_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_set_o |-> $past(req_valid_i));

  p_pulse_id_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_set_o |-> pend_id_o == $past(req_id_i));

  p_grp_mismatch_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_grp1_i && id_grp1_i) |=> !pend_set_o);

  p_secure_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ns_i && !(!req_grp1_i && id_grp1_i)) |=> pend_set_o);

  p_secdis_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sec_dis_i && !(!req_grp1_i && id_grp1_i)) |=> pend_set_o);

  p_read_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_dis_i || acc_ns_i) |-> acc_rdata_o == '0);

  p_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && (sec_dis_i || acc_ns_i)) |=> nsacc_q == $past(nsacc_q));
endmodule

bind sgi_accept_filter sgi_accept_filter_chk #(.REG_W(REG_W), .ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sec_dis_i   (sec_dis_i),
  .req_valid_i (req_valid_i),
  .req_id_i    (req_id_i),
  .req_grp1_i  (req_grp1_i),
  .req_ns_i    (req_ns_i),
  .id_grp1_i   (id_grp1_i),
  .acc_wr_i    (acc_wr_i),
  .acc_ns_i    (acc_ns_i),
  .acc_rdata_o (acc_rdata_o),
  .nsacc_q     (nsacc_q),
  .pend_set_o  (pend_set_o),
  .pend_id_o   (pend_id_o)
);

// File: tb/sgi_accept_filter_tb_top.sv
`timescale 1ns/1ps
module sgi_accept_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_dis = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_id = '0;
  logic        req_grp1 = 1'b0;
  logic        req_ns = 1'b0;
  logic        id_grp1 = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_ns = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        pend_set;
  logic [3:0]  pend_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sgi_accept_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sec_dis_i(sec_dis),
    .req_valid_i(req_valid), .req_id_i(req_id), .req_grp1_i(req_grp1),
    .req_ns_i(req_ns), .id_grp1_i(id_grp1),
    .acc_wr_i(acc_wr), .acc_ns_i(acc_ns), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(acc_rdata), .pend_set_o(pend_set), .pend_id_o(pend_id)
  );

  // {id[3:0], req_grp1, req_ns, id_grp1, sec_dis, expect_accept}
  // register holds 0xE4E4E4E4: level of ID n is n%4
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    {4'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 R4 downgrade, lvl1
    {4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 lvl0 drop
    {4'd6,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 lvl2
    {4'd5,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 lvl1 drop
    {4'd7,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 lvl3
    {4'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 secure mismatch
    {4'd8,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 mismatch, sec disabled
    {4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 lvl0 still accepted
    {4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 secure lvl0
    {4'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 secure downgrade
    {4'd13, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 lvl1 drop
    {4'd15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 R1 top field lvl3
    {4'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 secure G1
    {4'd9,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1}  // R2 R4 downgrade lvl1
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] d, input logic ns, input logic sd);
    @(negedge clk);
    acc_wr = 1'b1; acc_wdata = d; acc_ns = ns; sec_dis = sd;
    @(negedge clk);
    acc_wr = 1'b0; acc_ns = 1'b0; sec_dis = 1'b0;
  endtask

  task automatic reg_read(input logic ns, input logic sd, input logic [31:0] exp, input string req);
    @(negedge clk);
    acc_ns = ns; sec_dis = sd;
    #1;
    check(acc_rdata == exp, req, acc_rdata, exp);
    acc_ns = 1'b0; sec_dis = 1'b0;
  endtask

  task automatic send(input logic [3:0] id, input logic g1, input logic ns,
                      input logic ig1, input logic sd, input logic exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_grp1 = g1; req_ns = ns; id_grp1 = ig1; sec_dis = sd;
    @(negedge clk);
    req_valid = 1'b0; sec_dis = 1'b0;
    check(pend_set == exp, req, pend_set, exp);
    if (exp) check(pend_id == id, {req, " R8 id"}, pend_id, id);
    @(negedge clk);
    check(pend_set == 1'b0, "R8 single pulse", pend_set, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pend_set == 1'b0, "R8 reset pulse", pend_set, 0);
    rst_n = 1'b1;
    reg_read(1'b0, 1'b0, 32'h0, "R11 reset value");

    reg_write(32'hE4E4_E4E4, 1'b0, 1'b0);
    reg_read(1'b0, 1'b0, 32'hE4E4_E4E4, "R11 secure readback");
    reg_read(1'b1, 1'b0, 32'h0, "R9 ns read");
    reg_read(1'b0, 1'b1, 32'h0, "R9 secdis read");

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      send(v[8:5], v[4], v[3], v[2], v[1], v[0], "R2-table R4 R5");
    end

    // R10: ignored writes
    reg_write(32'h0, 1'b1, 1'b0);
    reg_read(1'b0, 1'b0, 32'hE4E4_E4E4, "R10 ns write ignored");
    reg_write(32'h0, 1'b0, 1'b1);
    reg_read(1'b0, 1'b0, 32'hE4E4_E4E4, "R10 secdis write ignored");
    send(4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10 level kept");

    // R12: same-cycle write uses old value (ID 6 level 2 -> 0)
    @(negedge clk);
    acc_wr = 1'b1; acc_wdata = 32'h0000_0004; acc_ns = 1'b0;
    req_valid = 1'b1; req_id = 4'd6; req_grp1 = 1'b1; req_ns = 1'b1; id_grp1 = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; req_valid = 1'b0;
    check(pend_set == 1'b1, "R12 old value used", pend_set, 1);
    send(4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R12 new value after");

    // R1: only ID 1 has level 1 (bits [3:2])
    send(4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1 id1 field");
    send(4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1 id0 field");
    send(4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1 id2 field");
    reg_write(32'hC000_0000, 1'b0, 1'b0);
    send(4'd15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R1 id15 field");
    send(4'd14, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1 id14 field");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule